// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the protocol engine of a 2048-byte serial memory reached over a two-wire I2C bus. It receives SCL and SDA already filtered and synchronised to the system clock, together with single-cycle start and stop pulses from a separate condition detector. It drives one open-drain pull-down enable for SDA. It decodes the device address byte and keeps an 11-bit word pointer. On the ninth clock of each byte it either acknowledges or samples the master's acknowledge. From these pieces it sequences byte writes, page writes, current-address reads, random reads and sequential reads.

Reads use a synchronous memory port: data returns on the clock after the enable. Writes go to an external page buffer through a strobe carrying address and data. A commit pulse at stop tells the write timer to begin programming. The timer reports back through a busy input. While busy is high the engine refuses its own address, and the master polls on that refusal. A write-protect input lets the address phases through but refuses every data byte.

Top module: `eei2c_slave`

## Requirements
- R1: A device byte whose bits 7..4 equal 1010 is acknowledged by pulling SDA low for the ninth clock. Any other value gets no acknowledge, and the engine then stays off the bus until the next start.
- R2: Bits 3..1 of the device byte become pointer bits 10..8. The next byte, the word byte, supplies bits 7..0. The first data byte of a write is strobed to the page buffer at that address.
- R3: SDA is released after reset. The enable changes only while SCL is low, except for the release forced by a start or stop. Read bytes leave most significant bit first.
- R4: While busy is high the device byte is not acknowledged and no buffer strobe or commit follows, so a master can poll for the end of a write cycle.
- R5: While write protect is high, the device and word bytes are acknowledged but the data byte is not. No buffer strobe occurs, and no commit occurs at the following stop.
- R6: Each acknowledged data byte is strobed to the buffer. The address then advances only in its low 4 bits, so writing past 16 bytes wraps within the page. A commit pulse is issued at stop only if at least one byte was taken since the last start.
- R7: In a read, an acknowledge from the master brings the next byte. A missing acknowledge releases SDA, and the engine waits for a stop.
- R8: The pointer holds the last address accessed plus one, and a current-address read starts there. Read increments wrap from 2047 to 0.
- R9: A repeated start after the word byte, followed by a device byte with bit 0 set, reads from the word address just loaded.
- R10: A start at any point abandons the byte in progress and restarts device-byte reception, leaving the pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level |
| start_i | input | 1 | One-cycle pulse on a start condition |
| stop_i | input | 1 | One-cycle pulse on a stop condition |
| wp_i | input | 1 | Write protect, high refuses data bytes |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | High pulls SDA low |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 11 | Memory read address |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| pb_wr_o | output | 1 | Page buffer write strobe |
| pb_addr_o | output | 11 | Page buffer write address |
| pb_data_o | output | 8 | Page buffer write data |
| pb_commit_o | output | 1 | Start the write cycle for buffered bytes |

## Verification
A wrong state or pointer shows up at the ports within one byte time. It appears as a misplaced acknowledge on the ninth clock, a read byte from the wrong address, or a buffer strobe with the wrong address or data. A scoreboard compares every buffer strobe and commit against the writes the stimulus predicts. Read data is compared against a reference image, so a pointer that fails to advance or to wrap is caught at the very next byte. A pointer disturbed by an aborted transfer is caught on the following current-address read.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } eei2c_state_t;
endpackage

// File: rtl/eei2c_bitfe.sv
// SCL edge detection, bit counter (0..BITS+1) and receive shift register.
module eei2c_bitfe #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            clr_i,
  output logic            rise_o,
  output logic            fall_o,
  output logic [CW-1:0]   cnt_o,
  output logic [BITS-1:0] byte_o
);
  logic            scl_q;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [BITS-1:0] sr_q, sr_n;

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
  assign cnt_o  = cnt_q;
  assign byte_o = sr_q;

  always_comb begin
    cnt_n = cnt_q;
    sr_n  = sr_q;
    if (clr_i) begin
      cnt_n = '0;
    end else if (rise_o && cnt_q < CW'(BITS + 1)) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q < CW'(BITS)) sr_n = {sr_q[BITS-2:0], sda_i};
    end else if (fall_o && cnt_q == CW'(BITS + 1)) begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      scl_q <= scl_i;
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
    end
  end
endmodule

// File: rtl/eei2c_ptr.sv
// Word address pointer: load, full-width read increment, in-page write increment.
module eei2c_ptr #(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_rd_i,
  input  logic          inc_pg_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_n;

  assign ptr_o = ptr_q;

  always_comb begin
    ptr_n = ptr_q;
    if (ld_i)          ptr_n = ld_val_i;
    else if (inc_rd_i) ptr_n = ptr_q + 1'b1;
    else if (inc_pg_i) ptr_n = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end
endmodule

// File: rtl/eei2c_slave.sv
module eei2c_slave
  import eei2c_pkg::*;
#(
  parameter int AW = eei2c_pkg::ADDR_W,
  parameter int DW = eei2c_pkg::DATA_W,
  parameter int PW = eei2c_pkg::PAGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          pb_wr_o,
  output logic [AW-1:0] pb_addr_o,
  output logic [DW-1:0] pb_data_o,
  output logic          pb_commit_o
);
  localparam int BW = AW - DW;
  localparam int CW = $clog2(DW + 2);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] ACK_BIT = CW'(DW);
  localparam logic [CW-1:0] ACK_END = CW'(DW + 1);

  eei2c_state_t  st_q, st_n;
  logic          oe_q, oe_n, sack_q, sack_n, wany_q, wany_n, fetch_q;
  logic [BW-1:0] blk_q, blk_n;
  logic [DW-1:0] tx_q, tx_n;
  logic          rise, fall, clr, ld, inc_rd, inc_pg, rd_en, pb_wr, commit;
  logic [CW-1:0] cnt, tx_idx;
  logic [DW-1:0] rx;
  logic [AW-1:0] ptr;

  assign clr    = start_i | stop_i;
  assign tx_idx = CW'(DW - 1) - cnt;

  eei2c_bitfe #(.BITS(DW)) bitfe_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .clr_i(clr),
    .rise_o(rise), .fall_o(fall), .cnt_o(cnt), .byte_o(rx)
  );

  eei2c_ptr #(.AW(AW), .PW(PW)) ptr_i (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_val_i({blk_q, rx}),
    .inc_rd_i(inc_rd), .inc_pg_i(inc_pg), .ptr_o(ptr)
  );

  always_comb begin
    st_n   = st_q;
    oe_n   = oe_q;
    sack_n = sack_q;
    wany_n = wany_q;
    blk_n  = blk_q;
    tx_n   = fetch_q ? mem_rd_data_i : tx_q;
    ld     = 1'b0;
    inc_rd = 1'b0;
    inc_pg = 1'b0;
    rd_en  = 1'b0;
    pb_wr  = 1'b0;
    commit = 1'b0;
    if (stop_i) begin
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      sack_n = 1'b0;
      wany_n = 1'b0;
      commit = wany_q;
    end else if (start_i) begin
      st_n   = ST_ADDR;
      oe_n   = 1'b0;
      sack_n = 1'b0;
      wany_n = 1'b0;
    end else if (fall && cnt == ACK_BIT) begin
      // ninth clock begins: answer a received byte or release after sending
      unique case (st_q)
        ST_ADDR: begin
          if (rx[DW-1:DW-4] == DEV_ID && !busy_i) begin
            blk_n  = rx[BW:1];
            oe_n   = 1'b1;
            sack_n = 1'b1;
            if (rx[0]) begin
              st_n   = ST_RDATA;
              rd_en  = 1'b1;
              inc_rd = 1'b1;
            end else begin
              st_n = ST_WADDR;
            end
          end else begin
            st_n = ST_WAIT;
            oe_n = 1'b0;
          end
        end
        ST_WADDR: begin
          ld     = 1'b1;
          oe_n   = 1'b1;
          sack_n = 1'b1;
          st_n   = ST_WDATA;
        end
        ST_WDATA: begin
          if (wp_i) begin
            st_n = ST_WAIT;
            oe_n = 1'b0;
          end else begin
            pb_wr  = 1'b1;
            inc_pg = 1'b1;
            wany_n = 1'b1;
            oe_n   = 1'b1;
            sack_n = 1'b1;
          end
        end
        ST_RDATA: oe_n = 1'b0;
        default: ;
      endcase
    end else if (fall && cnt == ACK_END) begin
      sack_n = 1'b0;
      oe_n   = (st_q == ST_RDATA) ? ~tx_n[DW-1] : 1'b0;
    end else if (fall && st_q == ST_RDATA && cnt != '0) begin
      oe_n = ~tx_q[tx_idx[IW-1:0]];
    end else if (rise && st_q == ST_RDATA && cnt == ACK_BIT && !sack_q) begin
      if (sda_i) begin
        st_n = ST_WAIT;
      end else begin
        rd_en  = 1'b1;
        inc_rd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      oe_q    <= 1'b0;
      sack_q  <= 1'b0;
      wany_q  <= 1'b0;
      blk_q   <= '0;
      tx_q    <= '0;
      fetch_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      oe_q    <= oe_n;
      sack_q  <= sack_n;
      wany_q  <= wany_n;
      blk_q   <= blk_n;
      tx_q    <= tx_n;
      fetch_q <= rd_en;
    end
  end

  assign sda_oe_o      = oe_q;
  assign mem_rd_en_o   = rd_en;
  assign mem_rd_addr_o = ptr;
  assign pb_wr_o       = pb_wr;
  assign pb_addr_o     = ptr;
  assign pb_data_o     = rx;
  assign pb_commit_o   = commit;
endmodule

// File: rtl/eei2c_chk.sv
module eei2c_chk #(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          wp_i,
  input logic          sda_oe_o,
  input logic          mem_rd_en_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic          pb_wr_o,
  input logic [AW-1:0] pb_addr_o,
  input logic          pb_commit_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i))); // R3

  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr_o |-> !wp_i); // R5

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    pb_commit_o |-> stop_i); // R6

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr_o |=> (pb_addr_o[AW-1:PW] == $past(pb_addr_o[AW-1:PW])) &&
                (pb_addr_o[PW-1:0] == PW'($past(pb_addr_o[PW-1:0]) + 1'b1))); // R6

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> (mem_rd_addr_o == AW'($past(mem_rd_addr_o) + 1'b1))); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pb_wr_o, mem_rd_en_o, pb_commit_o})); // R7
endmodule

bind eei2c_slave eei2c_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .start_i(start_i), .stop_i(stop_i),
  .wp_i(wp_i), .sda_oe_o(sda_oe_o), .mem_rd_en_o(mem_rd_en_o),
  .mem_rd_addr_o(mem_rd_addr_o), .pb_wr_o(pb_wr_o), .pb_addr_o(pb_addr_o),
  .pb_commit_o(pb_commit_o)
);

// File: tb/eei2c_slave_tb_top.sv
module eei2c_slave_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, msda, start_p, stop_p, wp, done;
  logic sda_oe, mem_rd_en, pb_wr, pb_commit, busy;
  logic [AW-1:0] mem_rd_addr, pb_addr;
  logic [DW-1:0] pb_data, mrd;
  wire bus = msda & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int busy_cnt;
  logic [7:0] mem_m [0:2047];
  logic [7:0] ref_m [0:2047];
  logic [7:0] pbuf_d [0:15];
  logic [10:0] pbuf_a [0:15];
  logic [15:0] pbuf_v;

  typedef struct packed { logic cm; logic [10:0] a; logic [7:0] d; } sb_t;
  sb_t sbq[$];

  assign busy = (busy_cnt != 0);

  eei2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus), .start_i(start_p),
    .stop_i(stop_p), .wp_i(wp), .busy_i(busy), .sda_oe_o(sda_oe),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr), .mem_rd_data_i(mrd),
    .pb_wr_o(pb_wr), .pb_addr_o(pb_addr), .pb_data_o(pb_data), .pb_commit_o(pb_commit)
  );

  // memory, page buffer and write timer models around the engine
  always @(posedge clk) begin
    if (mem_rd_en) mrd <= mem_m[mem_rd_addr];
    if (pb_wr) begin
      pbuf_d[pb_addr[3:0]] <= pb_data;
      pbuf_a[pb_addr[3:0]] <= pb_addr;
      pbuf_v[pb_addr[3:0]] <= 1'b1;
    end
    if (pb_commit) begin
      for (int i = 0; i < 16; i++) if (pbuf_v[i]) mem_m[pbuf_a[i]] <= pbuf_d[i];
      pbuf_v   <= '0;
      busy_cnt <= 300;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // scoreboard monitor: buffer strobes and commits (R2, R6)
  always @(negedge clk) begin
    if (rst_n && (pb_wr || pb_commit)) begin
      n_cmp++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL R6 unexpected strobe actual=wr%0b/cm%0b addr=%0h expected=none",
                 pb_wr, pb_commit, pb_addr);
      end else begin
        sb_t e;
        e = sbq.pop_front();
        if (e.cm != pb_commit || (!e.cm && (e.a != pb_addr || e.d != pb_data))) begin
          n_bad++;
          $display("FAIL R6 strobe actual=cm%0b %0h:%0h expected=cm%0b %0h:%0h",
                   pb_commit, pb_addr, pb_data, e.cm, e.a, e.d);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    msda = b; tick(4);
    scl = 1'b1; tick(4);
    r = bus; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic do_start();
    msda = 1'b1; tick(2);
    scl = 1'b1; tick(4);
    msda = 1'b0; start_p = 1'b1; tick(1);
    start_p = 1'b0; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic do_stop();
    msda = 1'b0; tick(4);
    scl = 1'b1; tick(4);
    msda = 1'b1; stop_p = 1'b1; tick(1);
    stop_p = 1'b0; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, nack);
  endtask

  task automatic recv_byte(input logic mnack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      d[i] = r;
    end
    bit_x(mnack, r);
  endtask

  task automatic read_n(input int first, input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(d == ref_m[(first + i) & 11'h7FF], tag, d, ref_m[(first + i) & 11'h7FF]);
    end
  endtask

  task automatic rd_rand(input logic [10:0] a, input int n, input string tag);
    logic nk;
    do_start();
    send_byte({4'hA, a[10:8], 1'b0}, nk); chk(nk == 1'b0, "R1 device ack", nk, 0);
    send_byte(a[7:0], nk);                chk(nk == 1'b0, "R2 word ack", nk, 0);
    do_start();
    send_byte({4'hA, a[10:8], 1'b1}, nk); chk(nk == 1'b0, "R9 read ack", nk, 0);
    read_n(a, n, tag);
    do_stop();
  endtask

  task automatic wr_seq(input logic [10:0] a, input int n, input logic [7:0] base);
    logic nk;
    logic [10:0] cur;
    cur = a;
    do_start();
    send_byte({4'hA, a[10:8], 1'b0}, nk); chk(nk == 1'b0, "R1 device ack", nk, 0);
    send_byte(a[7:0], nk);                chk(nk == 1'b0, "R2 word ack", nk, 0);
    for (int i = 0; i < n; i++) begin
      sbq.push_back({1'b0, cur, base + 8'(i)});
      ref_m[cur] = base + 8'(i);
      send_byte(base + 8'(i), nk);
      chk(nk == 1'b0, "R6 data ack", nk, 0);
      cur = {cur[10:4], cur[3:0] + 4'd1};
    end
    sbq.push_back({1'b1, 11'h0, 8'h0});
    do_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic nk;
    logic [7:0] d;
    done = 1'b0;
    for (int i = 0; i < 2048; i++) begin
      mem_m[i] = 8'((i * 37 + 11) & 255);
      ref_m[i] = 8'((i * 37 + 11) & 255);
    end
    pbuf_v = '0; busy_cnt = 0; mrd = '0;
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1; start_p = 1'b0; stop_p = 1'b0; wp = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk(sda_oe == 1'b0 && !pb_wr && !pb_commit, "R3 reset release", sda_oe, 0);

    // byte write at 0x3A5 (R2, R6)
    wr_seq(11'h3A5, 1, 8'h5C);
    tick(2);
    chk(busy == 1'b1, "R6 commit starts write cycle", busy, 1);

    // poll while busy: no ack (R4)
    do_start();
    send_byte(8'hA0, nk);
    chk(nk == 1'b1, "R4 busy nack", nk, 1);
    do_stop();
    while (busy) tick(1);

    // current-address read from last+1 (R8)
    do_start();
    send_byte(8'hA7, nk); chk(nk == 1'b0, "R8 read ack", nk, 0);
    read_n(11'h3A6, 1, "R8 current address");
    do_stop();

    // random + sequential read (R9, R7, R3 msb first)
    rd_rand(11'h3A5, 3, "R9 random sequential");

    // page write of 18 bytes at 0x1FC, wraps in page (R6)
    wr_seq(11'h1FC, 18, 8'hC0);
    while (busy) tick(1);
    rd_rand(11'h1F0, 16, "R6 page content");

    // write protect (R5)
    wp = 1'b1;
    do_start();
    send_byte(8'hA0, nk); chk(nk == 1'b0, "R5 device ack", nk, 0);
    send_byte(8'h10, nk); chk(nk == 1'b0, "R5 word ack", nk, 0);
    send_byte(8'h99, nk); chk(nk == 1'b1, "R5 data nack", nk, 1);
    do_stop();
    wp = 1'b0;
    tick(4);
    chk(busy == 1'b0, "R5 no write cycle", busy, 0);
    rd_rand(11'h010, 1, "R5 data unchanged");

    // address mismatch (R1)
    do_start();
    send_byte(8'hB0, nk); chk(nk == 1'b1, "R1 mismatch nack", nk, 1);
    send_byte(8'h00, nk); chk(nk == 1'b1, "R1 ignored after mismatch", nk, 1);
    do_stop();

    // master nack ends read: SDA released, no further bytes (R7)
    do_start();
    send_byte(8'hA1, nk); chk(nk == 1'b0, "R7 read ack", nk, 0);
    recv_byte(1'b1, d);
    chk(d == ref_m[11'h011], "R7 byte before nack", d, ref_m[11'h011]);
    bit_x(1'b1, nk);
    chk(nk == 1'b1 && sda_oe == 1'b0, "R7 released after nack", nk, 1);
    do_stop();

    // sequential read wrapping 2047 -> 0 (R8)
    rd_rand(11'h7FE, 3, "R8 wrap");

    // start mid word byte aborts; pointer stays at 0x001 (R10)
    do_start();
    send_byte(8'hA0, nk); chk(nk == 1'b0, "R10 device ack", nk, 0);
    for (int i = 0; i < 4; i++) bit_x(1'b0, nk);
    do_start();
    send_byte(8'hA1, nk); chk(nk == 1'b0, "R10 read ack", nk, 0);
    read_n(11'h001, 1, "R10 pointer kept");
    do_stop();

    tick(10);
    chk(sbq.size() == 0, "R6 all strobes seen", sbq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule